// File: doc/BRIEF.md
# Dual-Frame Line Fetcher and Streamer

The block builds one output video stream out of two frames that sit in memory. For each output row it first reads the matching row of frame A and then the matching row of frame B. Each row goes into its own on-chip line buffer. It then walks both buffers together one column at a time. It merges each pair of 32-bit words with a selectable per-pixel operation and sends the result on a valid/ready video stream. Every stream word carries two 16-bit pixels. A row of W pixels therefore becomes W/2 words, both in memory and on the stream.

Software sets up the frame geometry through plain configuration inputs: two base addresses, the width, the height and the row pitch (stride) in pixels. It then pulses `start`. The block captures the configuration at that pulse, so new values may be written during a frame. They apply from the next start. Memory is reached through a simple burst port. One request (word address and beat count) is accepted on valid/ready and is then answered by that many in-order response words, one per `rd_rsp_valid` cycle. The block has at most one request in flight and always accepts response words.

Output back-pressure: a word is transferred on a cycle where `m_tvalid` and `m_tready` are both high. While `m_tvalid` is high and `m_tready` is low, the block holds data and sideband stable and never withdraws valid. A word is never dropped or sent twice.

Top module: `dfl_top`

## Requirements
- R1: Row r of frame F is read from word address base_F + r*(stride/2) onward. For every row, all requests for frame A come before all requests for frame B. Rows are fetched in ascending order.
- R2: A row of width/2 words is covered by consecutive bursts of 64 words each, followed by a final shorter remainder. Every request length is between 1 and 64. A request's address and length stay stable while it waits for `rd_req_ready`.
- R3: No output word of row r is offered before every response word of row r has arrived for both frames.
- R4: Each frame yields exactly (width/2)*height output words in row-major order. Column c of row r is built from word c of that row in each frame.
- R5: `m_tuser` is 1 on the first word of a frame (row 0, column 0) and 0 on every other word.
- R6: `m_tlast` is 1 on the last word of every row (column width/2-1) and 0 elsewhere.
- R7: `m_tkeep` is always 4'b1111.
- R8: While `m_tvalid`=1 and `m_tready`=0, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values on the next cycle.
- R9: `cfg_mode`=0 outputs the frame A word unchanged. `cfg_mode`=1 outputs, in each of the four byte lanes, floor((a+b)/2) of the frame A and frame B bytes.
- R10: `done` goes high in the cycle after the last word of the frame is accepted. It falls in the cycle after the next accepted `start`. A `start` pulse while a frame is in progress has no effect.
- R11: Configuration is sampled at `start`. Changes to the configuration inputs during a frame do not affect that frame's requests or output.
- R12: After reset `m_tvalid`, `rd_req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a frame when idle |
| cfg_mode | input | 1 | 0: frame A pass-through, 1: byte-wise mean of A and B |
| cfg_base_a | input | ADDR_W | Word address of frame A row 0 |
| cfg_base_b | input | ADDR_W | Word address of frame B row 0 |
| cfg_width | input | DIM_W | Row width in pixels (even, 2..2*MAX_BEATS) |
| cfg_height | input | DIM_W | Rows per frame (at least 1) |
| cfg_stride | input | DIM_W | Row pitch in pixels (even) |
| done | output | 1 | Frame finished flag |
| rd_req_valid | output | 1 | Burst request valid |
| rd_req_ready | input | 1 | Burst request accepted |
| rd_req_addr | output | ADDR_W | Burst start word address |
| rd_req_len | output | LEN_W | Burst length in words (1..BURST_MAX) |
| rd_rsp_valid | input | 1 | Response word valid |
| rd_rsp_data | input | DATA_W | Response word |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Two pixels |
| m_tkeep | output | DATA_W/8 | Byte keep, all ones |
| m_tuser | output | 1 | Start of frame |
| m_tlast | output | 1 | End of row |

## Verification
A wrong column counter shows up at once: the first misplaced word carries data from the wrong buffer entry, and `m_tlast` or `m_tuser` appears on the wrong word of that same row. A wrong fill or row counter shows up at the memory port first, as a request address or length that differs from the computed list. It also leads to output words that appear before a row's responses are complete, which can be seen within one row. A stale or swapped frame select corrupts the averaged data in mode 1, on the first word of the affected row.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_SEND = 2'd3
  } dfl_state_e;
endpackage

// File: rtl/dfl_linebuf.sv
module dfl_linebuf #(
  parameter int DEPTH = 960,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dfl_mix.sv
module dfl_mix #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8
) (
  input  logic              mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [8:0] sum;
    assign sum = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]};
    assign y[8*i +: 8] = mode ? sum[8:1] : a[8*i +: 8];
  end
endmodule

// File: rtl/dfl_top.sv
module dfl_top
  import dfl_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DIM_W     = 12,
  parameter int MAX_BEATS = 960,
  parameter int BURST_MAX = 64,
  localparam int COL_W    = $clog2(MAX_BEATS),
  localparam int LEN_W    = $clog2(BURST_MAX + 1),
  localparam int KEEP_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_mode,
  input  logic [ADDR_W-1:0] cfg_base_a,
  input  logic [ADDR_W-1:0] cfg_base_b,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [DIM_W-1:0]  cfg_stride,
  output logic              done,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [LEN_W-1:0]  rd_req_len,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tuser,
  output logic              m_tlast
);
  dfl_state_e        st_q;
  logic              mode_q, sel_q, done_q;
  logic [ADDR_W-1:0] base_a_q, base_b_q;
  logic [DIM_W-1:0]  beats_q, height_q, pitch_q;
  logic [DIM_W-1:0]  row_q, fill_q, wr_ptr_q, col_q;
  logic [LEN_W-1:0]  left_q;

  logic [DIM_W-1:0]  remain;
  logic [LEN_W-1:0]  burst_len;
  logic [ADDR_W-1:0] line_base;
  logic              last_col, last_row;
  logic [DATA_W-1:0] rd_word [2];

  assign remain    = beats_q - fill_q;
  assign burst_len = (remain > DIM_W'(BURST_MAX)) ? LEN_W'(BURST_MAX) : LEN_W'(remain);
  assign line_base = (sel_q ? base_b_q : base_a_q) + ADDR_W'(row_q) * ADDR_W'(pitch_q);
  assign last_col  = (col_q == beats_q - 1'b1);
  assign last_row  = (row_q == height_q - 1'b1);

  assign rd_req_valid = (st_q == S_REQ);
  assign rd_req_addr  = line_base + ADDR_W'(fill_q);
  assign rd_req_len   = burst_len;

  // one line buffer per frame; index 0 holds frame A, 1 holds frame B
  for (genvar g = 0; g < 2; g++) begin : g_buf
    dfl_linebuf #(.DEPTH(MAX_BEATS), .W(DATA_W)) u_buf (
      .clk   (clk),
      .we    ((st_q == S_WAIT) && rd_rsp_valid && (sel_q == 1'(g))),
      .waddr (COL_W'(wr_ptr_q)),
      .wdata (rd_rsp_data),
      .raddr (COL_W'(col_q)),
      .rdata (rd_word[g])
    );
  end

  dfl_mix #(.DATA_W(DATA_W)) u_mix (
    .mode (mode_q),
    .a    (rd_word[0]),
    .b    (rd_word[1]),
    .y    (m_tdata)
  );

  assign m_tvalid = (st_q == S_SEND);
  assign m_tkeep  = '1;
  assign m_tuser  = (row_q == '0) && (col_q == '0);
  assign m_tlast  = last_col;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      mode_q   <= 1'b0;
      sel_q    <= 1'b0;
      done_q   <= 1'b0;
      base_a_q <= '0;
      base_b_q <= '0;
      beats_q  <= '0;
      height_q <= '0;
      pitch_q  <= '0;
      row_q    <= '0;
      fill_q   <= '0;
      wr_ptr_q <= '0;
      col_q    <= '0;
      left_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          mode_q   <= cfg_mode;
          base_a_q <= cfg_base_a;
          base_b_q <= cfg_base_b;
          beats_q  <= cfg_width >> 1;
          height_q <= cfg_height;
          pitch_q  <= cfg_stride >> 1;
          row_q    <= '0;
          sel_q    <= 1'b0;
          fill_q   <= '0;
          wr_ptr_q <= '0;
          col_q    <= '0;
          done_q   <= 1'b0;
          st_q     <= S_REQ;
        end
        S_REQ: if (rd_req_ready) begin
          left_q <= burst_len;
          fill_q <= fill_q + DIM_W'(burst_len);
          st_q   <= S_WAIT;
        end
        S_WAIT: if (rd_rsp_valid) begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
          left_q   <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            if (fill_q != beats_q) begin
              st_q <= S_REQ;
            end else if (!sel_q) begin
              sel_q    <= 1'b1;
              fill_q   <= '0;
              wr_ptr_q <= '0;
              st_q     <= S_REQ;
            end else begin
              col_q <= '0;
              st_q  <= S_SEND;
            end
          end
        end
        S_SEND: if (m_tready) begin
          if (!last_col) begin
            col_q <= col_q + 1'b1;
          end else if (last_row) begin
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end else begin
            row_q    <= row_q + 1'b1;
            sel_q    <= 1'b0;
            fill_q   <= '0;
            wr_ptr_q <= '0;
            st_q     <= S_REQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_stream_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_len != '0) && (rd_req_len <= LEN_W'(BURST_MAX)));

  assert_no_send_while_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !rd_req_valid);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !m_tvalid && !rd_req_valid);

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(m_tvalid && m_tready && m_tlast));
endmodule

// File: tb/sim_dfl_top.sv
`timescale 1ns/1ps
module sim_dfl_top;
  localparam int ADDR_W = 32, DATA_W = 32, DIM_W = 12, LEN_W = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_mode = 1'b0;
  logic [ADDR_W-1:0] cfg_base_a = '0, cfg_base_b = '0;
  logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0, cfg_stride = '0;
  logic done, rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [LEN_W-1:0]  rd_req_len;
  logic [DATA_W-1:0] rd_rsp_data = '0, m_tdata;
  logic m_tvalid, m_tready = 1'b0, m_tuser, m_tlast;
  logic [3:0] m_tkeep;

  always #2.5 clk = ~clk;

  dfl_top u0 (.*);

  int n_chk = 0, n_fail = 0;
  int pend = 0, pdelay = 0, rsp_total = 0, req_n = 0, mcyc = 0;
  logic [ADDR_W-1:0] paddr = '0;
  int req_addr [0:255];
  int req_len  [0:255];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [31:0] mdat(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h0F1E2D3C;
  endfunction

  function automatic logic [31:0] mean4(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = 8'((int'(a[8*i +: 8]) + int'(b[8*i +: 8])) / 2);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one burst at a time, two idle cycles before data
  task automatic mem_model();
    forever begin
      @(negedge clk);
      mcyc++;
      if (pend > 0 && pdelay == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mdat(paddr);
        paddr++;
        pend--;
        rsp_total++;
      end else begin
        rd_rsp_valid = 1'b0;
        if (pdelay > 0) pdelay--;
      end
      rd_req_ready = (pend == 0) && (mcyc % 3 != 0);
      if (rd_req_valid && rd_req_ready) begin
        if (req_n < 256) begin
          req_addr[req_n] = int'(rd_req_addr);
          req_len[req_n]  = int'(rd_req_len);
        end
        req_n++;
        pend   = int'(rd_req_len);
        paddr  = rd_req_addr;
        pdelay = 2;
      end
    end
  endtask

  task automatic run_frame(input bit mode, input int ba, input int bb, input int w,
                           input int h, input int s, input bit bp, input bit chg);
    int bw = w / 2;
    int nb = 0, cyc = 0, last_cyc = 0, r0 = rsp_total, q = 0;
    bit fin = 0;
    @(negedge clk);
    cfg_mode = mode; cfg_base_a = ADDR_W'(ba); cfg_base_b = ADDR_W'(bb);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h); cfg_stride = DIM_W'(s);
    req_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R10 done cleared by start", 64'(done), 0);
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (chg && cyc == 30) begin
        cfg_width = DIM_W'(w + 4); cfg_height = DIM_W'(h + 1);
        cfg_base_a = ADDR_W'(ba + 64); cfg_stride = DIM_W'(s + 2); cfg_mode = ~mode;
        start = 1'b1;
      end
      if (chg && cyc == 31) start = 1'b0;
      if (done) begin
        fin = 1;
        chk(nb == bw * h, "R4 word count", 64'(nb), 64'(bw * h));
        chk(cyc == last_cyc + 1, "R10 done timing", 64'(cyc), 64'(last_cyc + 1));
      end else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = bp ? lfsr[0] : 1'b1;
        if (m_tvalid && m_tready) begin
          int r = nb / bw, c = nb % bw;
          logic [31:0] a = mdat(32'(ba + r * (s / 2) + c));
          logic [31:0] b = mdat(32'(bb + r * (s / 2) + c));
          logic [31:0] e = mode ? mean4(a, b) : a;
          chk(m_tdata == e, mode ? "R9 mean data" : "R9 pass data", 64'(m_tdata), 64'(e));
          chk({m_tuser, m_tlast, m_tkeep} == {(nb == 0), (c == bw - 1), 4'hF},
              "R5 R6 R7 sideband", 64'({m_tuser, m_tlast, m_tkeep}),
              64'({(nb == 0), (c == bw - 1), 4'hF}));
          chk(rsp_total - r0 >= 2 * bw * (r + 1), "R3 row fetched first",
              64'(rsp_total - r0), 64'(2 * bw * (r + 1)));
          nb++;
          last_cyc = cyc;
        end
      end
    end
    m_tready = 1'b0;
    chk(fin, "R10 frame completes", 64'(fin), 1);
    for (int r = 0; r < h; r++) begin
      for (int f = 0; f < 2; f++) begin
        int off = 0;
        while (off < bw) begin
          int len = (bw - off > 64) ? 64 : bw - off;
          int ea = (f == 0 ? ba : bb) + r * (s / 2) + off;
          if (q < 256 && q < req_n)
            chk(req_addr[q] == ea && req_len[q] == len, "R1 R2 R11 request",
                64'({32'(req_addr[q]), 32'(req_len[q])}), 64'({32'(ea), 32'(len)}));
          else
            chk(0, "R1 R2 request missing", 64'(req_n), 64'(q + 1));
          q++;
          off += len;
        end
      end
    end
    chk(req_n == q, "R2 R11 request count", 64'(req_n), 64'(q));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({m_tvalid, rd_req_valid, done} == 3'b000, "R12 reset outputs",
        64'({m_tvalid, rd_req_valid, done}), 0);
  endtask

  task automatic t_small_pass();   // R1 R4 R5 R6 R9 mode 0
    run_frame(1'b0, 32'h100, 32'h800, 8, 3, 12, 1'b0, 1'b0);
  endtask

  task automatic t_long_mean();    // R2 split 64+6, R8 back-pressure, R9 mode 1
    run_frame(1'b1, 32'h2000, 32'h6000, 140, 2, 160, 1'b1, 1'b0);
  endtask

  task automatic t_cfg_change();   // R10 start ignored when busy, R11 config sampled
    run_frame(1'b1, 32'h40, 32'h9000, 6, 4, 6, 1'b1, 1'b1);
  endtask

  task automatic t_single();       // one word per row, tuser and tlast together
    run_frame(1'b0, 32'h10, 32'h20, 2, 2, 4, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    fork mem_model(); join_none
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_small_pass();
    t_long_mean();
    t_cfg_change();
    t_single();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule